// File: doc/BRIEF.md
# Pixel PLL Reprogramming Sequencer

This block reprograms the pixel-clock PLL of one of two display channels without glitching the pixel clock. After a one-cycle start pulse it latches a channel select, a reference-divider value and a packed divider word. It then drives a fixed list of register operations through a simple request/acknowledge register-access port. Most of these are read-modify-write operations that change only one field. Computing the divider values and building the register bridge are left to the surrounding logic.

The order is fixed:

- Park the pixel clock on the CPU clock.
- Hold the PLL in reset with atomic update enabled.
- Load the reference, feedback and post dividers.
- Wait for any pending atomic update to drain, then request a new one. Wait again.
- Clear the horizontal-total control register.
- Release the PLL.
- Wait a fixed settle time, because the PLL gives no lock indication.
- Move the pixel clock back to the PLL.

Both update waits are bounded. If the busy bit never clears, a sticky timeout flag is raised and the sequence carries on.

Top module: `ppll_reprog_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `timeout_o` and `reg_req_o` are all low.
- R2: The first write goes to the clock-source register and puts code 1 (CPU clock) in bits [1:0], keeping the other bits. The last write puts code 0 (PLL output) in bits [1:0], again keeping the other bits.
- R3: The second write goes to the PLL control register. It sets bit 0 (reset), bit 16 (atomic-update enable) and bit 17 (legacy-mode atomic-update enable) and keeps every other bit.
- R4: Three divider writes follow, in this order:
  - the reference-divider register bits [9:0] take `ref_div_i`;
  - the divider register bits [10:0] take `div_word_i[10:0]` (feedback);
  - the divider register bits [18:16] take `div_word_i[18:16]` (post-divider code).
  Each of these writes keeps all other bits.
- R5: The block then reads the reference-divider register until bit 15 (update busy) reads 0. It then writes that register with bit 15 set and the other bits kept, and polls bit 15 again in the same way.
- R6: Each poll makes at most POLL_LIMIT reads. If bit 15 is still 1 on the last read, the sequence continues and `timeout_o` is set. `timeout_o` stays set until the next accepted start.
- R7: An accepted start clears `timeout_o` on the next cycle.
- R8: After the second poll, the horizontal-total register is written with 0. The control register is then written with bits 0, 1 (sleep), 16 and 17 cleared and the other bits kept.
- R9: At least SETTLE_CYCLES clock cycles pass between the control-register release write and the write that restores the clock source.
- R10: `chan_i` = 0 selects these register indices: clock source 0x0D, control 0x02, reference divider 0x03, divider 0x07, horizontal total 0x09. `chan_i` = 1 selects 0x2D, 0x2A, 0x2B, 0x2C and 0x2E. A run touches only the selected set.
- R11: A run makes exactly nine writes and then pulses `done_o` high for one cycle with `busy_o` low. `reg_req_o` is low whenever the block is not busy. A start while a run is in progress is ignored.
- R12: A request keeps `reg_req_o`, `reg_wr_o`, `reg_addr_o` and `reg_wdata_o` steady until `reg_ack_i` is seen. Only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle start request, accepted when idle |
| chan_i | input | 1 | Channel select: 0 primary PLL, 1 secondary PLL |
| ref_div_i | input | 10 | Reference-divider value |
| div_word_i | input | 32 | Packed divider word: feedback in [10:0], post code in [18:16] |
| reg_req_o | output | 1 | Register-access request |
| reg_wr_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | 6 | Register index |
| reg_wdata_o | output | 32 | Write data |
| reg_rdata_i | input | 32 | Read data, valid with `reg_ack_i` on a read |
| reg_ack_i | input | 1 | Access completes in the cycle it is high |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| timeout_o | output | 1 | Sticky: a poll ran out of attempts |

## Verification
The assertions watch properties that hold on every cycle:
- the register-port request stays steady until acknowledged;
- `reg_req_o` is quiet while idle;
- `done_o` lasts one cycle;
- `timeout_o` is cleared by an accepted start and otherwise held while idle;
- every horizontal-total write carries zero;
- the settle gap before the clock-source restore is long enough.

The write order, the field merges against existing register contents, the choice of register set and the exact number of poll reads for a given busy pattern depend on a register model. Only the bench's scenarios can show them. The bench sweeps both channels against busy-bit patterns around the poll limit, with a start injected mid-run.

// File: rtl/ppll_seq_pkg.sv
// Package: shared widths, field layouts, register indices and operation types
// for the pixel PLL reprogramming sequencer.
package ppll_seq_pkg;

    localparam int DW       = 32;   // register data width
    localparam int AW       = 6;    // register index width
    localparam int REF_W    = 10;   // reference-divider field width
    localparam int FB_W     = 11;   // feedback-divider field width
    localparam int POST_LSB = 16;   // post-divider field position
    localparam int POST_W   = 3;    // post-divider field width
    localparam int SRC_W    = 2;    // clock-source select width

    localparam int BIT_RESET = 0;
    localparam int BIT_SLEEP = 1;
    localparam int BIT_AUPD  = 16;
    localparam int BIT_VAUPD = 17;
    localparam int BIT_UPD   = 15;  // update request (write) / busy (read)

    localparam logic [SRC_W-1:0] SRC_CPU = 2'd1;
    localparam logic [SRC_W-1:0] SRC_PLL = 2'd0;

    localparam logic [DW-1:0] M_SRC  = {{(DW-SRC_W){1'b0}}, {SRC_W{1'b1}}};
    localparam logic [DW-1:0] M_REF  = {{(DW-REF_W){1'b0}}, {REF_W{1'b1}}};
    localparam logic [DW-1:0] M_FB   = {{(DW-FB_W){1'b0}}, {FB_W{1'b1}}};
    localparam logic [DW-1:0] M_POST = {{(DW-POST_W){1'b0}}, {POST_W{1'b1}}} << POST_LSB;
    localparam logic [DW-1:0] M_UPD  = DW'(1) << BIT_UPD;
    localparam logic [DW-1:0] M_HOLD = (DW'(1) << BIT_RESET) | (DW'(1) << BIT_AUPD)
                                     | (DW'(1) << BIT_VAUPD);
    localparam logic [DW-1:0] M_RUN  = M_HOLD | (DW'(1) << BIT_SLEEP);

    typedef enum logic [1:0] {OP_RMW, OP_WRITE, OP_POLL, OP_WAIT} op_kind_e;
    typedef enum logic [2:0] {RS_SRC, RS_CTRL, RS_REF, RS_DIV, RS_HTOT} reg_sel_e;

    typedef struct packed {
        op_kind_e          kind;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     mask;   // bits replaced by a read-modify-write
        logic [DW-1:0]     val;
    } reg_op_t;

    localparam int STEP_W = 4;
    typedef logic [STEP_W-1:0] step_t;
    localparam step_t STEP_LAST = 4'd11;

    // Register index for a channel and a register role.
    function automatic logic [AW-1:0] reg_index(input logic chan, input reg_sel_e sel);
        logic [AW-1:0] idx;
        case (sel)
            RS_SRC:  idx = chan ? 6'h2D : 6'h0D;
            RS_CTRL: idx = chan ? 6'h2A : 6'h02;
            RS_REF:  idx = chan ? 6'h2B : 6'h03;
            RS_DIV:  idx = chan ? 6'h2C : 6'h07;
            default: idx = chan ? 6'h2E : 6'h09;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/ppll_step_decode.sv
// Module: ppll_step_decode
// Turns a step number into one register operation (kind, index, field mask,
// value) for the latched channel and divider words. Pure combinational.
// Assumes step numbers above STEP_LAST never occur.
module ppll_step_decode
    import ppll_seq_pkg::*;
(
    input  step_t             step_i,
    input  logic              chan_i,
    input  logic [REF_W-1:0]  ref_div_i,
    input  logic [DW-1:0]     div_word_i,
    output reg_op_t           op_o
);

    // Decode the step table.
    always_comb begin
        op_o = '{kind: OP_WAIT, addr: '0, mask: '0, val: '0};
        case (step_i)
            4'd0:  op_o = '{OP_RMW,  reg_index(chan_i, RS_SRC),  M_SRC,  DW'(SRC_CPU)};
            4'd1:  op_o = '{OP_RMW,  reg_index(chan_i, RS_CTRL), M_HOLD, M_HOLD};
            4'd2:  op_o = '{OP_RMW,  reg_index(chan_i, RS_REF),  M_REF,  DW'(ref_div_i)};
            4'd3:  op_o = '{OP_RMW,  reg_index(chan_i, RS_DIV),  M_FB,   div_word_i & M_FB};
            4'd4:  op_o = '{OP_RMW,  reg_index(chan_i, RS_DIV),  M_POST, div_word_i & M_POST};
            4'd5:  op_o = '{OP_POLL, reg_index(chan_i, RS_REF),  '0,     '0};
            4'd6:  op_o = '{OP_RMW,  reg_index(chan_i, RS_REF),  M_UPD,  M_UPD};
            4'd7:  op_o = '{OP_POLL, reg_index(chan_i, RS_REF),  '0,     '0};
            4'd8:  op_o = '{OP_WRITE, reg_index(chan_i, RS_HTOT), '1,    '0};
            4'd9:  op_o = '{OP_RMW,  reg_index(chan_i, RS_CTRL), M_RUN,  '0};
            4'd10: op_o = '{OP_WAIT, '0,                         '0,     '0};
            4'd11: op_o = '{OP_RMW,  reg_index(chan_i, RS_SRC),  M_SRC,  DW'(SRC_PLL)};
            default: op_o = '{OP_WAIT, '0, '0, '0};
        endcase
    end

endmodule

// File: rtl/ppll_reg_port.sv
// Module: ppll_reg_port
// Runs one register operation on the request/acknowledge port.
// - A plain write is a single write.
// - A poll is a single read.
// - A read-modify-write reads the register, merges the masked value and writes it back.
// Assumes go_i is raised only while idle. The port holds its request until
// the acknowledge arrives.
module ppll_reg_port
    import ppll_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_i,
    input  reg_op_t         op_i,
    output logic            req_o,
    output logic            wr_o,
    output logic [AW-1:0]   addr_o,
    output logic [DW-1:0]   wdata_o,
    input  logic [DW-1:0]   rdata_i,
    input  logic            ack_i,
    output logic            fin_o
);

    typedef enum logic [1:0] {P_IDLE, P_RD, P_WR} port_state_e;
    port_state_e state_q;
    reg_op_t     op_q;
    logic [DW-1:0] wdata_q;

    // Access phase sequencing and write-data merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= P_IDLE;
            op_q    <= '{OP_WAIT, '0, '0, '0};
            wdata_q <= '0;
        end else begin
            case (state_q)
                P_IDLE: if (go_i) begin
                    op_q <= op_i;
                    if (op_i.kind == OP_WRITE) begin
                        wdata_q <= op_i.val;
                        state_q <= P_WR;
                    end else begin
                        state_q <= P_RD;
                    end
                end
                P_RD: if (ack_i) begin
                    if (op_q.kind == OP_RMW) begin
                        wdata_q <= (rdata_i & ~op_q.mask) | (op_q.val & op_q.mask);
                        state_q <= P_WR;
                    end else begin
                        state_q <= P_IDLE;
                    end
                end
                P_WR: if (ack_i) state_q <= P_IDLE;
                default: state_q <= P_IDLE;
            endcase
        end
    end

    // Port outputs and completion strobe.
    always_comb begin
        req_o   = (state_q != P_IDLE);
        wr_o    = (state_q == P_WR);
        addr_o  = op_q.addr;
        wdata_o = wdata_q;
        fin_o   = ack_i && ((state_q == P_WR) ||
                            (state_q == P_RD && op_q.kind != OP_RMW));
    end

endmodule

// File: rtl/ppll_tick_counter.sv
// Module: ppll_tick_counter
// A plain up-counter with synchronous clear. Clear wins over increment.
// Used to count poll attempts and settle cycles.
// Assumes the owner stops incrementing before the count wraps.
module ppll_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_o <= '0;
        else if (clr_i) cnt_o <= '0;
        else if (inc_i) cnt_o <= cnt_o + W'(1);
    end

endmodule

// File: rtl/ppll_reprog_seq.sv
// Module: ppll_reprog_seq (top)
// Steps through the twelve-entry PLL reprogramming list for the selected
// channel. It bounds both update polls, times the settle wait and reports
// completion and timeout.
// Assumes POLL_LIMIT >= 1 and SETTLE_CYCLES >= 1. The register bridge must
// eventually acknowledge every request.
module ppll_reprog_seq
    import ppll_seq_pkg::*;
#(
    parameter int POLL_LIMIT    = 10000,
    parameter int SETTLE_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              chan_i,
    input  logic [REF_W-1:0]  ref_div_i,
    input  logic [DW-1:0]     div_word_i,
    output logic              reg_req_o,
    output logic              reg_wr_o,
    output logic [AW-1:0]     reg_addr_o,
    output logic [DW-1:0]     reg_wdata_o,
    input  logic [DW-1:0]     reg_rdata_i,
    input  logic              reg_ack_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o
);

    localparam int PCNT_W = $clog2(POLL_LIMIT + 1);
    localparam int SCNT_W = $clog2(SETTLE_CYCLES + 1);

    typedef enum logic [2:0] {T_IDLE, T_LAUNCH, T_XFER, T_SETTLE, T_DONE} seq_state_e;

    seq_state_e          state_q;
    step_t               step_q;
    logic                chan_q;
    logic [REF_W-1:0]    ref_q;
    logic [DW-1:0]       div_q;
    logic                timeout_q;

    reg_op_t             cur_op;
    logic                go, fin;
    logic [PCNT_W-1:0]   poll_cnt;
    logic [SCNT_W-1:0]   settle_cnt;
    logic                is_poll, poll_busy, last_try, settle_end;
    logic                advance, retry, give_up, accept;

    ppll_step_decode u_dec (
        .step_i     (step_q),
        .chan_i     (chan_q),
        .ref_div_i  (ref_q),
        .div_word_i (div_q),
        .op_o       (cur_op)
    );

    ppll_reg_port u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go),
        .op_i    (cur_op),
        .req_o   (reg_req_o),
        .wr_o    (reg_wr_o),
        .addr_o  (reg_addr_o),
        .wdata_o (reg_wdata_o),
        .rdata_i (reg_rdata_i),
        .ack_i   (reg_ack_i),
        .fin_o   (fin)
    );

    ppll_tick_counter #(.W(PCNT_W)) u_poll_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (advance || accept),
        .inc_i (retry),
        .cnt_o (poll_cnt)
    );

    ppll_tick_counter #(.W(SCNT_W)) u_settle_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (state_q == T_LAUNCH && cur_op.kind == OP_WAIT),
        .inc_i (state_q == T_SETTLE),
        .cnt_o (settle_cnt)
    );

    // Step-completion decisions for polls, transfers and the settle wait.
    always_comb begin
        accept     = (state_q == T_IDLE) && start_i;
        go         = (state_q == T_LAUNCH) && (cur_op.kind != OP_WAIT);
        is_poll    = (cur_op.kind == OP_POLL);
        poll_busy  = reg_rdata_i[BIT_UPD];
        last_try   = (poll_cnt == PCNT_W'(POLL_LIMIT - 1));
        settle_end = (settle_cnt == SCNT_W'(SETTLE_CYCLES - 1));
        retry      = (state_q == T_XFER) && fin && is_poll && poll_busy && !last_try;
        give_up    = (state_q == T_XFER) && fin && is_poll && poll_busy && last_try;
        advance    = ((state_q == T_XFER) && fin && !retry) ||
                     ((state_q == T_SETTLE) && settle_end);
    end

    // Main sequencer: latch a request, walk the steps, finish with a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= T_IDLE;
            step_q    <= '0;
            chan_q    <= 1'b0;
            ref_q     <= '0;
            div_q     <= '0;
            timeout_q <= 1'b0;
        end else begin
            case (state_q)
                T_IDLE: if (start_i) begin
                    chan_q    <= chan_i;
                    ref_q     <= ref_div_i;
                    div_q     <= div_word_i;
                    step_q    <= '0;
                    timeout_q <= 1'b0;
                    state_q   <= T_LAUNCH;
                end
                T_LAUNCH: state_q <= (cur_op.kind == OP_WAIT) ? T_SETTLE : T_XFER;
                T_XFER, T_SETTLE: begin
                    if (give_up) timeout_q <= 1'b1;
                    if (retry) begin
                        state_q <= T_LAUNCH;
                    end else if (advance) begin
                        if (step_q == STEP_LAST) begin
                            state_q <= T_DONE;
                        end else begin
                            step_q  <= step_q + STEP_W'(1);
                            state_q <= T_LAUNCH;
                        end
                    end
                end
                T_DONE:  state_q <= T_IDLE;
                default: state_q <= T_IDLE;
            endcase
        end
    end

    // Status outputs.
    always_comb begin
        busy_o    = (state_q != T_IDLE) && (state_q != T_DONE);
        done_o    = (state_q == T_DONE);
        timeout_o = timeout_q;
    end

endmodule

// File: rtl/ppll_reprog_seq_chk.sv
// Module: ppll_reprog_seq_chk
// Checker bound to the sequencer. It watches only the ports and keeps one
// counter of its own for the settle window.
module ppll_reprog_seq_chk
    import ppll_seq_pkg::*;
#(
    parameter int SETTLE_CYCLES = 500000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            timeout_o,
    input logic            reg_req_o,
    input logic            reg_wr_o,
    input logic [AW-1:0]   reg_addr_o,
    input logic [DW-1:0]   reg_wdata_o,
    input logic            reg_ack_i
);

    localparam int GW = $clog2(SETTLE_CYCLES + 1);

    logic          wr_done, is_release, is_restore;
    logic [GW-1:0] gap_q;

    // Classify completed writes.
    always_comb begin
        wr_done    = reg_req_o && reg_wr_o && reg_ack_i;
        is_release = wr_done && (reg_addr_o == 6'h02 || reg_addr_o == 6'h2A)
                     && !reg_wdata_o[BIT_RESET];
        is_restore = wr_done && (reg_addr_o == 6'h0D || reg_addr_o == 6'h2D)
                     && (reg_wdata_o[SRC_W-1:0] == SRC_PLL);
    end

    // Cycles since the last release write, saturating at the settle length.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  gap_q <= '0;
        else if (is_release)                         gap_q <= '0;
        else if (gap_q != GW'(SETTLE_CYCLES))        gap_q <= gap_q + GW'(1);
    end

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && !reg_ack_i) |=> (reg_req_o && $stable(reg_addr_o) &&
                                       $stable(reg_wr_o) && $stable(reg_wdata_o)));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !reg_req_o);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !done_o) |=> !timeout_o);

    p_timeout_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(timeout_o));

    p_htotal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && reg_wr_o && (reg_addr_o == 6'h09 || reg_addr_o == 6'h2E))
        |-> (reg_wdata_o == '0));

    p_settle_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_restore |-> (gap_q == GW'(SETTLE_CYCLES)));

endmodule

bind ppll_reprog_seq ppll_reprog_seq_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o),
    .reg_req_o   (reg_req_o),
    .reg_wr_o    (reg_wr_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_ack_i   (reg_ack_i)
);

// File: tb/ppll_reprog_seq_test.sv
`timescale 1ns/1ps
module ppll_reprog_seq_test;

    localparam int L = 8;    // poll limit under test
    localparam int S = 20;   // settle cycles under test

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        chan_i = 1'b0;
    logic [9:0]  ref_div_i = '0;
    logic [31:0] div_word_i = '0;
    logic        reg_req_o, reg_wr_o;
    logic [5:0]  reg_addr_o;
    logic [31:0] reg_wdata_o;
    logic [31:0] reg_rdata_i = '0;
    logic        reg_ack_i = 1'b0;
    logic        busy_o, done_o, timeout_o;

    always #2.5 clk = ~clk;

    ppll_reprog_seq #(.POLL_LIMIT(L), .SETTLE_CYCLES(S)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .ref_div_i(ref_div_i), .div_word_i(div_word_i),
        .reg_req_o(reg_req_o), .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o),
        .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i), .reg_ack_i(reg_ack_i),
        .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- register model ----------------
    logic [31:0] mem [64];
    logic [31:0] init_mem [64];
    logic [5:0]  log_a [16];
    logic [31:0] log_d [16];
    int          log_c [16];
    int          wr_n = 0;
    int          ref_reads = 0;
    int          busy_cnt = 0;
    int          arm1 = 0, arm2 = 0;
    int          cyc = 0;
    logic [5:0]  cur_ref = 6'h03;
    logic [31:0] rd;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (reg_req_o && !reg_ack_i) begin
            reg_ack_i <= 1'b1;
            if (reg_wr_o) begin
                mem[reg_addr_o] <= reg_wdata_o;
                if (wr_n < 16) begin
                    log_a[wr_n] <= reg_addr_o;
                    log_d[wr_n] <= reg_wdata_o;
                    log_c[wr_n] <= cyc;
                end
                if (wr_n == 4) busy_cnt <= arm1;
                if (wr_n == 5) busy_cnt <= arm2;
                wr_n <= wr_n + 1;
            end else begin
                rd = mem[reg_addr_o];
                if (reg_addr_o == cur_ref) begin
                    rd[15] = (busy_cnt > 0);
                    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
                    ref_reads <= ref_reads + 1;
                end
                reg_rdata_i <= rd;
            end
        end else begin
            reg_ack_i <= 1'b0;
        end
    end

    // ---------------- one reprogramming run ----------------
    task automatic run(input bit ch, input logic [9:0] rv, input logic [31:0] dv,
                       input int b1, input int b2, input bit poke, input int seed);
        logic [5:0]  a_src, a_ctl, a_ref, a_div, a_ht;
        logic [5:0]  o_src, o_ctl, o_ref, o_div, o_ht;
        logic [5:0]  ea [9];
        logic [31:0] ed [9];
        int n;
        int exp_reads;
        bit exp_to;
        string tag;
        a_src = ch ? 6'h2D : 6'h0D;  a_ctl = ch ? 6'h2A : 6'h02;
        a_ref = ch ? 6'h2B : 6'h03;  a_div = ch ? 6'h2C : 6'h07;
        a_ht  = ch ? 6'h2E : 6'h09;
        o_src = ch ? 6'h0D : 6'h2D;  o_ctl = ch ? 6'h02 : 6'h2A;
        o_ref = ch ? 6'h03 : 6'h2B;  o_div = ch ? 6'h07 : 6'h2C;
        o_ht  = ch ? 6'h09 : 6'h2E;
        @(negedge clk);
        for (int a = 0; a < 64; a++) begin
            mem[a]      = (32'h6B43_A9B5 * (a + 3)) ^ (32'(seed) << 7);
            init_mem[a] = mem[a];
        end
        arm1 = b1; arm2 = b2; busy_cnt = 0; wr_n = 0; ref_reads = 0; cur_ref = a_ref;
        start_i = 1'b1; chan_i = ch; ref_div_i = rv; div_word_i = dv;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R11 busy after start", 32'(busy_o), 32'd1);
        chk(timeout_o == 1'b0, "R7 timeout cleared by start", 32'(timeout_o), 32'd0);
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
            start_i = poke && (n == 30);
            chan_i  = poke ? ~ch : ch;
        end
        start_i = 1'b0;
        chk(done_o == 1'b1, "R11 done seen", 32'(done_o), 32'd1);
        chk(busy_o == 1'b0, "R11 busy low with done", 32'(busy_o), 32'd0);

        // expected write list
        ed[0] = (init_mem[a_src] & ~32'h3) | 32'h1;                ea[0] = a_src;
        ed[1] = init_mem[a_ctl] | 32'h0003_0001;                   ea[1] = a_ctl;
        ed[2] = (init_mem[a_ref] & ~32'h0000_83FF) | 32'(rv);       ea[2] = a_ref;
        ed[3] = (init_mem[a_div] & ~32'h7FF) | (dv & 32'h7FF);      ea[3] = a_div;
        ed[4] = (ed[3] & ~32'h7_0000) | (dv & 32'h7_0000);         ea[4] = a_div;
        ed[5] = ed[2] | 32'h8000;                                  ea[5] = a_ref;
        ed[6] = 32'h0;                                             ea[6] = a_ht;
        ed[7] = ed[1] & ~32'h0003_0003;                            ea[7] = a_ctl;
        ed[8] = ed[0] & ~32'h3;                                    ea[8] = a_src;

        chk(wr_n == 9, "R11 nine writes", 32'(wr_n), 32'd9);
        for (int i = 0; i < 9; i++) begin
            case (i)
                0: tag = "R2 source to CPU clock";
                1: tag = "R3 control hold";
                2: tag = "R4 reference divider";
                3: tag = "R4 feedback divider";
                4: tag = "R4 post divider";
                5: tag = "R5 commit request";
                6: tag = "R8 horizontal total zero";
                7: tag = "R8 control release";
                default: tag = "R2 source back to PLL";
            endcase
            chk(log_a[i] == ea[i], {tag, " index R10"}, 32'(log_a[i]), 32'(ea[i]));
            chk(log_d[i] == ed[i], tag, log_d[i], ed[i]);
        end
        exp_reads = 2 + ((b1 + 1 < L) ? b1 + 1 : L) + ((b2 + 1 < L) ? b2 + 1 : L);
        exp_to    = (b1 >= L) || (b2 >= L);
        chk(ref_reads == exp_reads, "R5 R6 poll read count", 32'(ref_reads), 32'(exp_reads));
        chk(timeout_o == exp_to, "R6 timeout flag", 32'(timeout_o), 32'(exp_to));
        chk((log_c[8] - log_c[7] >= S) && (log_c[8] - log_c[7] <= S + 8),
            "R9 settle gap", 32'(log_c[8] - log_c[7]), 32'(S));
        chk(mem[o_src] == init_mem[o_src] && mem[o_ctl] == init_mem[o_ctl] &&
            mem[o_ref] == init_mem[o_ref] && mem[o_div] == init_mem[o_div] &&
            mem[o_ht] == init_mem[o_ht], "R10 other channel untouched",
            mem[o_ctl], init_mem[o_ctl]);
        @(negedge clk);
        chk(done_o == 1'b0, "R11 done one cycle", 32'(done_o), 32'd0);
        repeat (4) @(negedge clk);
        chk(!reg_req_o && !busy_o, "R11 quiet after run", 32'(reg_req_o), 32'd0);
        chk(timeout_o == exp_to, "R6 timeout held while idle", 32'(timeout_o), 32'(exp_to));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        int id;
        int b1s [7];
        int b2s [7];
        b1s = '{0, 1, 7, 8, 0, 12, 3};
        b2s = '{0, 2, 0, 0, 8, 12, 7};
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !timeout_o && !reg_req_o, "R1 state in reset",
            {busy_o, done_o, timeout_o, reg_req_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && !done_o && !timeout_o && !reg_req_o, "R1 idle after reset",
            {busy_o, done_o, timeout_o, reg_req_o}, 32'd0);
        id = 0;
        for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < 7; k++) begin
                run(c[0], 10'((37 * id + 5) & 32'h3FF),
                    32'h9E37_79B9 * 32'(id + 1), b1s[k], b2s[k],
                    (k == 1) || (k == 4), id);
                id++;
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule